// File: doc/BRIEF.md
# Polled Serial Port Register Front End

This block puts a byte-wide serial transceiver behind four 32-bit registers in a processor's address space. Software busy-waits on a one-bit ready flag in a control register, then moves one byte through the matching data register. On the receive side the ready flag means a byte is waiting. On the transmit side it means the single holding slot is free. Accessing the data register clears the flag, so software never writes a status bit.

The serial core sits on the other side. It delivers received bytes as a one-cycle `rx_valid` pulse, which the block always accepts. It takes bytes to send through a `tx_valid`/`tx_ready` handshake. If a new byte arrives before software has read the previous one, the new byte replaces it and a sticky overrun flag is raised. Bus reads are combinational. Their side effects take hold at the clock edge that ends the access cycle.

Top module: `serial_port_regs`

## Requirements
- R1: After reset, the receive control register reads 0, the transmit control register reads 1, and `tx_valid` is low.
- R2: The registers sit at fixed offsets from `BASE` (default 0xFFFF0000): receive control at +0x0, receive data at +0x4, transmit control at +0x8, transmit data at +0xC. Any other address reads 0, and a write to it changes nothing.
- R3: An `rx_valid` pulse stores `rx_data`, and from the next cycle bit 0 (ready) of the receive control register reads 1.
- R4: A read of the receive data register returns the stored byte in bits 7:0 with bits 31:8 zero. If no byte arrives in that cycle, ready reads 0 from the next cycle.
- R5: An `rx_valid` pulse while ready is 1, with no receive data read in the same cycle, replaces the stored byte and sets bit 1 (overrun) of the receive control register.
- R6: Overrun stays set until the receive control register is read, and that read clears it. If a new overrun event falls in the same cycle as that read, overrun stays 1. Bits 31:2 always read 0.
- R7: If an `rx_valid` pulse falls in the same cycle as a receive data read, the read returns the old byte, the new byte is kept, ready stays 1, and overrun is not set.
- R8: A write to the transmit data register while the transmit ready bit is 1 latches bits 7:0 onto `tx_data`. From the next cycle `tx_valid` is high and the transmit control register reads 0.
- R9: `tx_valid` and `tx_data` hold steady until a cycle in which `tx_ready` is high. From the cycle after that one, `tx_valid` is low and the transmit control register reads 1.
- R10: A write to the transmit data register while the transmit ready bit is 0 is ignored, and `tx_data` keeps the pending byte.
- R11: Writes to the two control registers and to the receive data register have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; read side effects occur at the clock edge |
| bus_rdata | output | 32 | Combinational read data |
| rx_valid | input | 1 | Received byte present (one-cycle pulse) |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Byte pending for the serial core |
| tx_ready | input | 1 | Serial core accepts the pending byte |
| tx_data | output | 8 | Pending byte |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a byte arrival and a software read of the receive data register. The second pair is a byte arrival that overruns and a software read of the receive control register, which would clear overrun. Directed sequences force both pairs onto exactly the same edge. Random traffic, with `rx_valid` and bus reads asserted often, produces many more such collisions. In each case the bench judges the result through later reads of the receive registers, which are compared with a bench model built from R5 to R7. The transmit handshake arriving in the same cycle as a late write is provoked in the same way and checked on `tx_data`.

// File: rtl/serial_port_regs.sv
module serial_port_regs #(
  parameter logic [31:0] BASE = 32'hFFFF_0000,
  parameter int          BW   = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [7:0]  tx_data
);
  localparam logic [31:0] RXC = BASE;
  localparam logic [31:0] RXD = BASE + 32'd4;
  localparam logic [31:0] TXC = BASE + 32'd8;
  localparam logic [31:0] TXD = BASE + 32'd12;
  localparam int          PAD = 32 - BW;

  logic [BW-1:0] rx_byte, tx_byte;
  logic          rx_full, rx_ovr, tx_empty;

  wire rd_rxc = bus_rd && bus_addr == RXC;
  wire rd_rxd = bus_rd && bus_addr == RXD;
  wire wr_txd = bus_wr && bus_addr == TXD;
  wire tx_done = tx_valid && tx_ready;

  assign tx_valid = !tx_empty;
  assign tx_data  = tx_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_byte <= '0;
      rx_full <= 1'b0;
      rx_ovr  <= 1'b0;
    end else begin
      if (rx_valid) rx_byte <= rx_data;
      if (rx_valid)    rx_full <= 1'b1;
      else if (rd_rxd) rx_full <= 1'b0;
      if (rx_valid && rx_full && !rd_rxd) rx_ovr <= 1'b1;
      else if (rd_rxc)                    rx_ovr <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_byte  <= '0;
      tx_empty <= 1'b1;
    end else if (tx_done) begin
      tx_empty <= 1'b1;
    end else if (wr_txd && tx_empty) begin
      tx_empty <= 1'b0;
      tx_byte  <= bus_wdata[BW-1:0];
    end
  end

  always_comb begin
    unique case (bus_addr)
      RXC:     bus_rdata = {30'd0, rx_ovr, rx_full};
      RXD:     bus_rdata = {{PAD{1'b0}}, rx_byte};
      TXC:     bus_rdata = {31'd0, tx_empty};
      TXD:     bus_rdata = {{PAD{1'b0}}, tx_byte};
      default: bus_rdata = 32'd0;
    endcase
  end

  a_r3_rx_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> rx_full && rx_byte == $past(rx_data));
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && !rx_valid) |=> !rx_full);
  a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_full && !rd_rxd) |=> rx_ovr);
  a_r7_no_false_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && !rd_rxc && !rx_ovr) |=> !rx_ovr);
  a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data));
  a_r9_tx_release: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_valid);
  a_r8_tx_load: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && !tx_valid) |=> tx_valid && tx_data == $past(bus_wdata[7:0]));
endmodule

// File: tb/serial_port_regs_test.sv
module serial_port_regs_test;
  localparam logic [31:0] B = 32'hFFFF_0000;
  localparam logic [31:0] RXC = B, RXD = B + 4, TXC = B + 8, TXD = B + 12;

  logic clk = 0, rst_n = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0;
  logic bus_wr = 0, bus_rd = 0, rx_valid = 0, tx_ready = 0;
  logic [7:0] rx_data = 0;
  logic [31:0] bus_rdata;
  logic tx_valid;
  logic [7:0] tx_data;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_rx = 0, m_tx = 0;
  bit m_full = 0, m_ovr = 0, m_empty = 1;

  always #4 clk = ~clk;

  serial_port_regs uut (.clk, .rst_n, .bus_addr, .bus_wr, .bus_wdata, .bus_rd,
    .bus_rdata, .rx_valid, .rx_data, .tx_valid, .tx_ready, .tx_data);

  function automatic logic [31:0] exp_rd(logic [31:0] a);
    case (a)
      RXC: return {30'd0, m_ovr, m_full};
      RXD: return {24'd0, m_rx};
      TXC: return {31'd0, m_empty};
      TXD: return {24'd0, m_tx};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit r, bit w, logic [31:0] a, logic [31:0] d,
                     bit rv, logic [7:0] rb, bit tr, string tag);
    bit rrd, rrc;
    @(negedge clk);
    bus_rd = r; bus_wr = w; bus_addr = a; bus_wdata = d;
    rx_valid = rv; rx_data = rb; tx_ready = tr;
    #1;
    if (r) chk(tag, bus_rdata, exp_rd(a));
    chk({tag, " tx"}, {23'd0, tx_valid, tx_data}, {23'd0, !m_empty, m_tx});
    rrd = r && a == RXD;
    rrc = r && a == RXC;
    if (rv && m_full && !rrd) m_ovr = 1; else if (rrc) m_ovr = 0;
    if (rv) begin m_full = 1; m_rx = rb; end else if (rrd) m_full = 0;
    if (!m_empty && tr) m_empty = 1;
    else if (m_empty && w && a == TXD) begin m_empty = 0; m_tx = d[7:0]; end
  endtask

  task automatic rd(logic [31:0] a, string tag);
    cyc(1, 0, a, 0, 0, 0, 0, tag);
  endtask

  initial begin
    #(8 * 150000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    @(negedge clk); bus_rd = 1; bus_addr = RXC; #1 chk("R1 rxc", bus_rdata, 0);
    bus_addr = TXC; #1 chk("R1 txc", bus_rdata, 1);
    chk("R1 tx_valid", {31'd0, tx_valid}, 0);
    // R2 unmapped address
    cyc(1, 1, B + 16, 32'hFF, 0, 0, 0, "R2");
    chk("R2 other", bus_rdata, 0);
    // R3/R4 capture and read
    cyc(0, 0, 0, 0, 1, 8'hA5, 0, "R3");
    rd(RXC, "R3"); chk("R3 ready", bus_rdata, 1);
    rd(RXD, "R4"); chk("R4 data", bus_rdata, 32'h0000_00A5);
    rd(RXC, "R4"); chk("R4 cleared", bus_rdata, 0);
    // R5 overrun
    cyc(0, 0, 0, 0, 1, 8'h11, 0, "R5");
    cyc(0, 0, 0, 0, 1, 8'h22, 0, "R5");
    rd(RXD, "R5"); chk("R5 byte", bus_rdata, 32'h22);
    // R6 sticky, cleared by read, collision keeps it
    rd(RXC, "R6"); chk("R6 sticky", bus_rdata, 2);
    rd(RXC, "R6"); chk("R6 cleared", bus_rdata, 0);
    cyc(0, 0, 0, 0, 1, 8'h31, 0, "R6");
    cyc(0, 0, 0, 0, 1, 8'h32, 0, "R6");
    cyc(1, 0, RXC, 0, 1, 8'h33, 0, "R6");
    rd(RXC, "R6"); chk("R6 collide", bus_rdata, 3);
    rd(RXD, "R6");
    // R7 arrival same cycle as data read
    cyc(0, 0, 0, 0, 1, 8'h44, 0, "R7");
    cyc(1, 0, RXD, 0, 1, 8'h55, 0, "R7"); chk("R7 old", bus_rdata, 32'h44);
    rd(RXC, "R7"); chk("R7 ready", bus_rdata, 1);
    rd(RXD, "R7"); chk("R7 new", bus_rdata, 32'h55);
    // R11 writes to other registers
    cyc(0, 1, RXC, 32'h3, 0, 0, 0, "R11");
    cyc(0, 1, RXD, 32'h77, 0, 0, 0, "R11");
    cyc(0, 1, TXC, 32'h0, 0, 0, 0, "R11");
    rd(RXC, "R11"); chk("R11 rxc", bus_rdata, 0);
    rd(TXC, "R11"); chk("R11 txc", bus_rdata, 1);
    rd(RXD, "R11"); chk("R11 rxd", bus_rdata, 32'h55);
    // R8 / R10 / R9 transmit path
    cyc(0, 1, TXD, 32'hDEAD_BE5A, 0, 0, 0, "R8");
    rd(TXC, "R8"); chk("R8 busy", bus_rdata, 0);
    chk("R8 tx", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, 8'h5A});
    cyc(0, 1, TXD, 32'h66, 0, 0, 0, "R10");
    chk("R10 kept", {24'd0, tx_data}, 32'h5A);
    cyc(0, 1, TXD, 32'h67, 0, 0, 1, "R9");
    cyc(1, 0, TXC, 0, 0, 0, 0, "R9");
    chk("R9 free", bus_rdata, 1);
    chk("R9 tx_valid", {31'd0, tx_valid}, 0);
    chk("R10 late", {24'd0, tx_data}, 32'h5A);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a;
      int k = $urandom_range(0, 4);
      a = (k == 4) ? B + 32'd16 + ($urandom_range(0, 7) << 2) : B + 32'(k * 4);
      cyc($urandom_range(0, 1), $urandom_range(0, 2) == 0, a, $urandom,
          $urandom_range(0, 2) == 0, 8'($urandom), $urandom_range(0, 2) == 0,
          k == 0 ? "R6" : k == 1 ? "R4" : k == 2 ? "R9" : k == 3 ? "R8" : "R2");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule